// File: doc/BRIEF.md
# DMA Channel Completion and Fault Status

This block holds the per-channel termination status and interrupt requests of a multi-channel DMA engine. It does not move data.

A start strobe asks a channel to run. In that same cycle the block checks the channel's configuration: the byte count, the source and destination addresses, the transfer unit size and the device port size. If the configuration is sound, the channel becomes active and loads its remaining byte count. If the configuration is faulty, the channel stays idle and the abnormal-completion flag is set.

While a channel is active:
- Each transfer-progress strobe takes one unit off the remaining count.
- When the count reaches zero, the channel goes idle and sets its normal-completion flag.
- A bus error strobe on the source side or the destination side ends the channel abnormally and records which side failed.

Every flag is sticky until software clears it with a write-one-to-clear. Each channel drives one interrupt line. That line is the OR of its enabled completion flags.

Top module: `dma_status_unit`

## Requirements
- R1: During reset and after it, every channel is idle, all four status flags are 0 and every interrupt line is 0.
- R2: A start on an idle channel with a sound configuration makes `ch_active` 1 from the next cycle and loads the remaining count from `cfg_count`.
- R3: While a channel is active, each `xfer_step` takes the unit size in bytes off the remaining count. Unit code 0 is 1 byte, 1 is 2 bytes and 2 is 4 bytes. The step that brings the count to zero makes the channel idle and sets `st_normal` on the next cycle.
- R4: A start with `cfg_count` equal to zero leaves the channel idle and sets `st_abort`.
- R5: A start with a count that is not a multiple of the unit size leaves the channel idle and sets `st_abort`.
- R6: A start with a source or destination address that is not a multiple of the unit size leaves the channel idle and sets `st_abort`.
- R7: A start with an illegal unit/port pairing leaves the channel idle and sets `st_abort`. The pairing is illegal when the unit code is 3, when the port code is 3 (port codes: 0 = 8 bits, 1 = 16 bits, 2 = 32 bits), or when the unit is wider than the port.
- R8: A bus error on an active channel makes it idle and sets `st_abort`, together with `st_berr_src` for a source-side error and/or `st_berr_dst` for a destination-side error. This takes precedence over a step in the same cycle. A bus error on an idle channel is ignored.
- R9: Writing `clr_en` with a 1 in a bit of `clr_bits` clears that flag. Bit 0 clears normal, bit 1 clears abort, bit 2 clears source bus error and bit 3 clears destination bus error. A flag being set in the same cycle stays set.
- R10: `irq` of a channel equals (`ie_normal` AND `st_normal`) OR (`ie_abort` AND `st_abort`).
- R11: A start on a channel that is already active is ignored.
- R12: Channels are independent: stimulus on one channel never changes another channel's state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_count | input | NUM_CH*CNT_W | Byte count per channel |
| cfg_src | input | NUM_CH*ADDR_W | Source address per channel |
| cfg_dst | input | NUM_CH*ADDR_W | Destination address per channel |
| cfg_unit | input | NUM_CH*2 | Transfer unit size code per channel |
| cfg_port | input | NUM_CH*2 | Device port size code per channel |
| start | input | NUM_CH | Start strobe per channel |
| xfer_step | input | NUM_CH | One unit transferred |
| berr_src | input | NUM_CH | Source-side bus error strobe |
| berr_dst | input | NUM_CH | Destination-side bus error strobe |
| clr_en | input | NUM_CH | Flag clear write strobe |
| clr_bits | input | NUM_CH*4 | Write-one-to-clear mask per channel |
| ie_normal | input | NUM_CH | Normal-completion interrupt enable |
| ie_abort | input | NUM_CH | Abnormal-completion interrupt enable |
| ch_active | output | NUM_CH | Channel is running |
| st_normal | output | NUM_CH | Normal-completion flag |
| st_abort | output | NUM_CH | Abnormal-completion flag |
| st_berr_src | output | NUM_CH | Source-side bus error flag |
| st_berr_dst | output | NUM_CH | Destination-side bus error flag |
| irq | output | NUM_CH | Interrupt request per channel |

## Verification
The bench builds the block with four channels, an 8-bit count and 8-bit addresses.

The narrow count keeps transfers to a handful of steps, so normal completion, a bus error part way through a transfer and a start on a busy channel all occur many times in a few thousand cycles. The narrow addresses make misaligned source and destination values common.

Because all four channels are present, collisions between one channel's strobes and another channel's state are exercised on every cycle.

// File: rtl/dma_stat_pkg.sv
package dma_stat_pkg;

  typedef enum logic [1:0] {
    UNIT_1B  = 2'd0,
    UNIT_2B  = 2'd1,
    UNIT_4B  = 2'd2,
    UNIT_RSV = 2'd3
  } unit_e;

  typedef enum logic [1:0] {
    PORT_8   = 2'd0,
    PORT_16  = 2'd1,
    PORT_32  = 2'd2,
    PORT_RSV = 2'd3
  } port_e;

  // clear mask bit positions
  localparam int CLR_NORM = 0;
  localparam int CLR_ABRT = 1;
  localparam int CLR_BSRC = 2;
  localparam int CLR_BDST = 3;
  localparam int CLR_W    = 4;

  function automatic logic [2:0] unit_bytes(input logic [1:0] code);
    case (code)
      UNIT_1B: unit_bytes = 3'd1;
      UNIT_2B: unit_bytes = 3'd2;
      UNIT_4B: unit_bytes = 3'd4;
      default: unit_bytes = 3'd4;
    endcase
  endfunction

endpackage

// File: rtl/dma_cfg_check.sv
module dma_cfg_check
  import dma_stat_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int ADDR_W = 32
) (
  input  logic [CNT_W-1:0]  count,
  input  logic [ADDR_W-1:0] src,
  input  logic [ADDR_W-1:0] dst,
  input  logic [1:0]        unit,
  input  logic [1:0]        port,
  output logic              fault
);

  logic [1:0] low_mask;
  logic       zero_cnt, cnt_odd, src_odd, dst_odd, pair_bad;

  always_comb begin
    low_mask = unit_bytes(unit)[1:0] - 2'd1;
    zero_cnt = (count == '0);
    cnt_odd  = (count[1:0] & low_mask) != 2'b00;
    src_odd  = (src[1:0] & low_mask) != 2'b00;
    dst_odd  = (dst[1:0] & low_mask) != 2'b00;
    // codes are ordered by width, so a numeric compare finds a unit wider than the port
    pair_bad = (unit == UNIT_RSV) || (port == PORT_RSV) || (unit > port);
    fault    = zero_cnt || cnt_odd || src_odd || dst_odd || pair_bad;
  end

endmodule

// File: rtl/dma_chan_status.sv
module dma_chan_status
  import dma_stat_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CNT_W-1:0]  count,
  input  logic [1:0]        unit,
  input  logic              fault,
  input  logic              start,
  input  logic              step,
  input  logic              be_src,
  input  logic              be_dst,
  input  logic              clr_en,
  input  logic [CLR_W-1:0]  clr_bits,
  input  logic              ie_norm,
  input  logic              ie_abrt,
  output logic              active,
  output logic              f_norm,
  output logic              f_abrt,
  output logic              f_bsrc,
  output logic              f_bdst,
  output logic              irq
);

  logic [CNT_W-1:0] rem_q;
  logic [1:0]       unit_q;
  logic [CNT_W-1:0] ub;
  logic             start_ok, start_bad, be_hit, last_step, take_step;
  logic [CLR_W-1:0] clr_hit;

  always_comb begin
    ub        = CNT_W'(unit_bytes(unit_q));
    start_ok  = start && !active && !fault;
    start_bad = start && !active && fault;
    be_hit    = active && (be_src || be_dst);
    take_step = active && step && !be_hit;
    last_step = take_step && (rem_q == ub);
    clr_hit   = clr_en ? clr_bits : '0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active <= 1'b0;
      rem_q  <= '0;
      unit_q <= UNIT_1B;
      f_norm <= 1'b0;
      f_abrt <= 1'b0;
      f_bsrc <= 1'b0;
      f_bdst <= 1'b0;
    end else begin
      if (be_hit || last_step) begin
        active <= 1'b0;
      end else if (start_ok) begin
        active <= 1'b1;
      end
      if (start_ok) begin
        rem_q  <= count;
        unit_q <= unit;
      end else if (take_step) begin
        rem_q  <= rem_q - ub;
      end
      // a flag being set wins over a clear in the same cycle
      f_norm <= last_step                 || (f_norm && !clr_hit[CLR_NORM]);
      f_abrt <= start_bad || be_hit       || (f_abrt && !clr_hit[CLR_ABRT]);
      f_bsrc <= (active && be_src)        || (f_bsrc && !clr_hit[CLR_BSRC]);
      f_bdst <= (active && be_dst)        || (f_bdst && !clr_hit[CLR_BDST]);
    end
  end

  assign irq = (ie_norm && f_norm) || (ie_abrt && f_abrt);

  AST_GOOD_START_RUNS: assert property (@(posedge clk) disable iff (!rst_n)
    start && !active && !fault |=> active); // R2
  AST_NORM_ONLY_FROM_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(f_norm) |-> $past(active)); // R3
  AST_BAD_START_STAYS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    start && !active && fault |=> !active && f_abrt); // R4
  AST_RUN_COUNT_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    active |-> ((rem_q[1:0] & (ub[1:0] - 2'd1)) == 2'b00) && rem_q != '0); // R5
  AST_BUSERR_ENDS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    active && (be_src || be_dst) |=> !active && f_abrt); // R8
  AST_IDLE_BUSERR_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    !active && !f_bsrc && be_src |=> !f_bsrc); // R8
  AST_SET_BEATS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    active && be_dst && clr_en && clr_bits[CLR_BDST] |=> f_bdst); // R9
  AST_QUIET_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    !f_norm && !f_abrt |-> !irq); // R10
  AST_BUSY_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    active && start && !step && !be_src && !be_dst |=> active && $stable(rem_q)); // R11

endmodule

// File: rtl/dma_status_unit.sv
module dma_status_unit
  import dma_stat_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int CNT_W  = 16,
  parameter int ADDR_W = 32
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [NUM_CH*CNT_W-1:0]  cfg_count,
  input  logic [NUM_CH*ADDR_W-1:0] cfg_src,
  input  logic [NUM_CH*ADDR_W-1:0] cfg_dst,
  input  logic [NUM_CH*2-1:0]      cfg_unit,
  input  logic [NUM_CH*2-1:0]      cfg_port,
  input  logic [NUM_CH-1:0]        start,
  input  logic [NUM_CH-1:0]        xfer_step,
  input  logic [NUM_CH-1:0]        berr_src,
  input  logic [NUM_CH-1:0]        berr_dst,
  input  logic [NUM_CH-1:0]        clr_en,
  input  logic [NUM_CH*4-1:0]      clr_bits,
  input  logic [NUM_CH-1:0]        ie_normal,
  input  logic [NUM_CH-1:0]        ie_abort,
  output logic [NUM_CH-1:0]        ch_active,
  output logic [NUM_CH-1:0]        st_normal,
  output logic [NUM_CH-1:0]        st_abort,
  output logic [NUM_CH-1:0]        st_berr_src,
  output logic [NUM_CH-1:0]        st_berr_dst,
  output logic [NUM_CH-1:0]        irq
);

  logic [NUM_CH-1:0] fault;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    dma_cfg_check #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) i_check (
      .count (cfg_count[c*CNT_W +: CNT_W]),
      .src   (cfg_src[c*ADDR_W +: ADDR_W]),
      .dst   (cfg_dst[c*ADDR_W +: ADDR_W]),
      .unit  (cfg_unit[c*2 +: 2]),
      .port  (cfg_port[c*2 +: 2]),
      .fault (fault[c])
    );

    dma_chan_status #(.CNT_W(CNT_W)) i_chan (
      .clk      (clk),
      .rst_n    (rst_n),
      .count    (cfg_count[c*CNT_W +: CNT_W]),
      .unit     (cfg_unit[c*2 +: 2]),
      .fault    (fault[c]),
      .start    (start[c]),
      .step     (xfer_step[c]),
      .be_src   (berr_src[c]),
      .be_dst   (berr_dst[c]),
      .clr_en   (clr_en[c]),
      .clr_bits (clr_bits[c*CLR_W +: CLR_W]),
      .ie_norm  (ie_normal[c]),
      .ie_abrt  (ie_abort[c]),
      .active   (ch_active[c]),
      .f_norm   (st_normal[c]),
      .f_abrt   (st_abort[c]),
      .f_bsrc   (st_berr_src[c]),
      .f_bdst   (st_berr_dst[c]),
      .irq      (irq[c])
    );
  end

  AST_RESET_QUIET: assert property (@(posedge clk)
    !rst_n |=> ch_active == '0 && st_abort == '0 && st_normal == '0); // R1

endmodule

// File: tb/test_dma_status_unit.sv
module test_dma_status_unit;
  localparam int NCH   = 4;
  localparam int CW    = 8;
  localparam int AW    = 8;
  localparam int CLK_P = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #(CLK_P/2) clk = ~clk;

  logic [CW-1:0] t_cnt [NCH];
  logic [AW-1:0] t_src [NCH];
  logic [AW-1:0] t_dst [NCH];
  logic [1:0]    t_unit[NCH];
  logic [1:0]    t_port[NCH];
  logic [3:0]    t_clr [NCH];

  logic [NCH*CW-1:0] cfg_count;
  logic [NCH*AW-1:0] cfg_src, cfg_dst;
  logic [NCH*2-1:0]  cfg_unit, cfg_port;
  logic [NCH*4-1:0]  clr_bits;
  logic [NCH-1:0] start = '0, xfer_step = '0, berr_src = '0, berr_dst = '0;
  logic [NCH-1:0] clr_en = '0, ie_normal = '0, ie_abort = '0;
  logic [NCH-1:0] ch_active, st_normal, st_abort, st_berr_src, st_berr_dst, irq;

  always_comb begin
    for (int c = 0; c < NCH; c++) begin
      cfg_count[c*CW +: CW] = t_cnt[c];
      cfg_src[c*AW +: AW]   = t_src[c];
      cfg_dst[c*AW +: AW]   = t_dst[c];
      cfg_unit[c*2 +: 2]    = t_unit[c];
      cfg_port[c*2 +: 2]    = t_port[c];
      clr_bits[c*4 +: 4]    = t_clr[c];
    end
  end

  dma_status_unit #(.NUM_CH(NCH), .CNT_W(CW), .ADDR_W(AW)) i_dma_status_unit (
    .clk(clk), .rst_n(rst_n), .cfg_count(cfg_count), .cfg_src(cfg_src),
    .cfg_dst(cfg_dst), .cfg_unit(cfg_unit), .cfg_port(cfg_port), .start(start),
    .xfer_step(xfer_step), .berr_src(berr_src), .berr_dst(berr_dst),
    .clr_en(clr_en), .clr_bits(clr_bits), .ie_normal(ie_normal),
    .ie_abort(ie_abort), .ch_active(ch_active), .st_normal(st_normal),
    .st_abort(st_abort), .st_berr_src(st_berr_src), .st_berr_dst(st_berr_dst),
    .irq(irq)
  );

  // behavioural reference
  bit m_act[NCH], m_n[NCH], m_a[NCH], m_s[NCH], m_d[NCH];
  int m_rem[NCH], m_ub[NCH];

  function automatic bit cfg_bad(int c);
    int ub, pb;
    if (t_unit[c] == 3 || t_port[c] == 3) return 1;
    ub = 1 << t_unit[c];
    pb = 1 << t_port[c];
    if (ub > pb) return 1;                       // R7
    if (t_cnt[c] == 0) return 1;                 // R4
    if (int'(t_cnt[c]) % ub != 0) return 1;      // R5
    if (int'(t_src[c]) % ub != 0 || int'(t_dst[c]) % ub != 0) return 1; // R6
    return 0;
  endfunction

  always @(posedge clk) begin
    for (int c = 0; c < NCH; c++) begin
      if (!rst_n) begin
        m_act[c] = 0; m_n[c] = 0; m_a[c] = 0; m_s[c] = 0; m_d[c] = 0; m_rem[c] = 0; m_ub[c] = 1;
      end else begin
        bit was, hit, fin, bad_go, ok_go;
        bit cn, ca, cs, cd;
        was = m_act[c];
        hit = was && (berr_src[c] || berr_dst[c]);
        fin = was && !hit && xfer_step[c] && (m_rem[c] - m_ub[c] == 0);
        bad_go = !was && start[c] && cfg_bad(c);
        ok_go  = !was && start[c] && !cfg_bad(c);
        cn = clr_en[c] && t_clr[c][0];
        ca = clr_en[c] && t_clr[c][1];
        cs = clr_en[c] && t_clr[c][2];
        cd = clr_en[c] && t_clr[c][3];
        if (cn) m_n[c] = 0;
        if (ca) m_a[c] = 0;
        if (cs) m_s[c] = 0;
        if (cd) m_d[c] = 0;
        if (fin) m_n[c] = 1;
        if (hit || bad_go) m_a[c] = 1;
        if (was && berr_src[c]) m_s[c] = 1;
        if (was && berr_dst[c]) m_d[c] = 1;
        if (was && !hit && xfer_step[c]) m_rem[c] -= m_ub[c];
        if (hit || fin) m_act[c] = 0;
        else if (ok_go) begin
          m_act[c] = 1; m_rem[c] = t_cnt[c]; m_ub[c] = 1 << t_unit[c];
        end
      end
    end
  end

  int n_cmp = 0, n_bad = 0;
  bit running = 1;

  task automatic chk(string tag, int c, bit act, bit exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s ch%0d t=%0t: got %0b expected %0b", tag, c, $time, act, exp);
    end
  endtask

  always @(negedge clk) if (running) begin
    for (int c = 0; c < NCH; c++) begin
      if (!rst_n) begin
        chk("R1 active", c, ch_active[c], 0);
        chk("R1 irq", c, irq[c], 0);
      end else begin
        chk("R2/R11 active", c, ch_active[c], m_act[c]);
        chk("R3 normal", c, st_normal[c], m_n[c]);
        chk("R4/R5/R6/R7 abort", c, st_abort[c], m_a[c]);
        chk("R8 src berr", c, st_berr_src[c], m_s[c]);
        chk("R8 dst berr", c, st_berr_dst[c], m_d[c]);
        chk("R10 irq", c, irq[c], (ie_normal[c] && m_n[c]) || (ie_abort[c] && m_a[c]));
      end
    end
  end

  task automatic quiet();
    start = '0; xfer_step = '0; berr_src = '0; berr_dst = '0; clr_en = '0;
  endtask

  task automatic tick();
    @(posedge clk); #1; quiet();
  endtask

  task automatic go(int c, int cnt, int s, int d, int u, int p);
    t_cnt[c] = CW'(cnt); t_src[c] = AW'(s); t_dst[c] = AW'(d);
    t_unit[c] = 2'(u); t_port[c] = 2'(p); start[c] = 1;
  endtask

  initial begin
    #(CLK_P*200000);
    if (running) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    for (int c = 0; c < NCH; c++) begin
      t_cnt[c] = '0; t_src[c] = '0; t_dst[c] = '0; t_unit[c] = '0; t_port[c] = '0; t_clr[c] = '0;
    end
    ie_normal = '1; ie_abort = '1;
    repeat (3) @(posedge clk);                      // R1 checked while reset held
    #1; rst_n = 1;
    // R2 R3: 4-byte unit on 32-bit port, two steps to finish
    go(0, 8, 4, 8, 2, 2); tick();
    xfer_step[0] = 1; tick();
    start[0] = 1; tick();                           // R11 start while busy
    xfer_step[0] = 1; tick(); tick();
    // R4 zero count, R5 odd count, R6 misaligned dst, R7 unit wider than port
    go(1, 0, 0, 0, 0, 0); tick();
    clr_en[1] = 1; t_clr[1] = 4'b0010; tick();      // R9 clear abort
    go(1, 3, 0, 0, 1, 1); tick();
    go(2, 4, 0, 1, 1, 2); tick();
    go(3, 4, 0, 0, 2, 1); tick();
    // R8 bus error beats a step; R9 set beats clear; R12 other channels untouched
    go(0, 16, 0, 0, 1, 1); tick();
    berr_dst[0] = 1; xfer_step[0] = 1; clr_en[0] = 1; t_clr[0] = 4'b1010; tick();
    berr_src[2] = 1; tick();                        // R8 idle channel ignores
    ie_normal = 4'b0101; ie_abort = 4'b1010; tick(); // R10
    // randomized traffic
    for (int cyc = 0; cyc < 4000; cyc++) begin
      for (int c = 0; c < NCH; c++) begin
        int u, p, ub;
        if ($urandom_range(7) == 0) begin
          u = ($urandom_range(7) < 6) ? $urandom_range(2) : 3;
          p = ($urandom_range(7) < 6) ? $urandom_range(2) : 3;
          ub = (u == 3) ? 1 : (1 << u);
          go(c, ($urandom_range(4) == 0) ? $urandom_range(255) : ub * $urandom_range(1, 4),
             ($urandom_range(3) == 0) ? $urandom_range(255) : ub * $urandom_range(60),
             ($urandom_range(3) == 0) ? $urandom_range(255) : ub * $urandom_range(60), u, p);
        end
        xfer_step[c] = ($urandom_range(1) == 1);
        berr_src[c]  = ($urandom_range(39) == 0);
        berr_dst[c]  = ($urandom_range(39) == 0);
        if ($urandom_range(5) == 0) begin
          clr_en[c] = 1; t_clr[c] = 4'($urandom_range(15));
        end
        if ($urandom_range(15) == 0) ie_normal[c] = ~ie_normal[c];
        if ($urandom_range(15) == 0) ie_abort[c]  = ~ie_abort[c];
      end
      tick();
    end
    tick(); tick();
    running = 0;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule